// File: doc/BRIEF.md
# Paged Program Counter Unit

This block keeps the 13-bit instruction address of a small 8-bit controller core and chooses the next fetch address every clock. The counter's low byte works as an ordinary data register: the datapath can read it, and the datapath can write it. The five upper bits are never written directly. They come from a separate 5-bit page register, which the datapath loads through its own strobe, or they come from a value popped off the return stack.

A jump or a call carries an 11-bit target in the opcode. The two page bits above that target come from bits 4:3 of the page register. When the datapath writes the low byte, all five upper bits come from the page register. A return loads the whole address from the popped value and does not use the page register. The block also presents the address of the following instruction, which is the value the core pushes on a call or an interrupt. Instruction decode, the ALU and the stack memory sit outside this block.

Top module: `paged_pc`

## Requirements
- R1: While reset is held, and until the first update after it is released, `fetch_addr` is 0x0000 and the page register is 0.
- R2: If `inc_en` is the only control asserted, `fetch_addr` increases by one on the next clock edge. After 0x1FFF it wraps to 0x0000.
- R3: If no control is asserted, `fetch_addr` keeps its value.
- R4: A jump or a call (`jump_en` or `call_en`) loads `fetch_addr` with {page[4:3], `branch_target`[10:0]} on the next edge.
- R5: A low-byte write (`low_wr_en`) loads `fetch_addr` with {page[4:0], `low_wr_data`[7:0]} on the next edge.
- R6: A return (`ret_en`) loads all 13 bits of `fetch_addr` from `ret_addr`, whatever the page register holds.
- R7: Calls, jumps and returns leave the page register unchanged. Only `latch_wr_en` writes it.
- R8: `push_addr` always equals `fetch_addr` + 1, wrapped to 13 bits.
- R9: `low_rd_data` always equals bits 7:0 of `fetch_addr`.
- R10: When several controls are asserted together, they are served in this order: return first, then jump or call, then low-byte write, then increment.
- R11: A page-register write takes effect at the clock edge. A low-byte write or a branch in the same cycle still uses the page value from before that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| inc_en | input | 1 | Step to the next sequential address |
| jump_en | input | 1 | Jump to the opcode target |
| call_en | input | 1 | Call to the opcode target |
| branch_target | input | 11 | Opcode target bits 10:0 |
| low_wr_en | input | 1 | Datapath write of the low byte |
| low_wr_data | input | 8 | Value written to the low byte |
| ret_en | input | 1 | Return, taking the popped address |
| ret_addr | input | 13 | Address popped from the stack |
| latch_wr_en | input | 1 | Write strobe for the page register |
| latch_wr_data | input | 5 | New page register value (data bus bits 4:0) |
| fetch_addr | output | 13 | Current fetch address |
| low_rd_data | output | 8 | Read value of the low byte |
| push_addr | output | 13 | Next-instruction address to push on a call |

## Verification
Every control acts on the clock edge where it is sampled. The new `fetch_addr` and `low_rd_data` are therefore due one edge after the stimulus, while `push_addr` follows the current address combinationally. The driver applies each stimulus at the falling edge and places the expected address in a queue. The monitor removes one entry from that queue shortly after each rising edge and compares it, so each result is checked in exactly the cycle it appears. The push value is checked inside the same half cycle in which the stimulus is applied, before the edge that consumes it.

// File: rtl/pcu_pkg.sv
package pcu_pkg;

    // Source of the next program counter value, ordered by priority
    typedef enum logic [2:0] {
        SRC_HOLD   = 3'd0,
        SRC_INC    = 3'd1,
        SRC_LOW    = 3'd2,
        SRC_BRANCH = 3'd3,
        SRC_RET    = 3'd4
    } pc_src_e;

endpackage

// File: rtl/pcu_select.sv
module pcu_select
    import pcu_pkg::*;
(
    input  logic    inc_en,
    input  logic    jump_en,
    input  logic    call_en,
    input  logic    low_wr_en,
    input  logic    ret_en,
    output pc_src_e src
);

    // Priority: return, branch, low-byte write, increment
    always_comb begin
        if (ret_en)                  src = SRC_RET;
        else if (jump_en || call_en) src = SRC_BRANCH;
        else if (low_wr_en)          src = SRC_LOW;
        else if (inc_en)             src = SRC_INC;
        else                         src = SRC_HOLD;
    end

endmodule

// File: rtl/pcu_incr.sv
module pcu_incr #(
    parameter int W = 13
) (
    input  logic [W-1:0] cur,
    output logic [W-1:0] nxt
);

    // Modulo-2^W increment; the carry out is dropped on purpose
    assign nxt = cur + {{(W-1){1'b0}}, 1'b1};

endmodule

// File: rtl/pcu_target.sv
module pcu_target #(
    parameter int PC_W   = 13,
    parameter int DATA_W = 8,
    parameter int OPC_W  = 11
) (
    input  logic [PC_W-DATA_W-1:0] page,
    input  logic [OPC_W-1:0]       opc_target,
    input  logic [DATA_W-1:0]      low_data,
    output logic [PC_W-1:0]        branch_addr,
    output logic [PC_W-1:0]        low_addr
);

    localparam int LAT_W  = PC_W - DATA_W;
    localparam int PAGE_W = PC_W - OPC_W;

    // A branch takes only the top page bits of the latch
    assign branch_addr = {page[LAT_W-1 -: PAGE_W], opc_target};
    // A low-byte write takes the whole latch as the upper bits
    assign low_addr    = {page, low_data};

endmodule

// File: rtl/paged_pc.sv
module paged_pc
    import pcu_pkg::*;
#(
    parameter int PC_W   = 13,
    parameter int DATA_W = 8,
    parameter int OPC_W  = 11
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   inc_en,
    input  logic                   jump_en,
    input  logic                   call_en,
    input  logic [OPC_W-1:0]       branch_target,
    input  logic                   low_wr_en,
    input  logic [DATA_W-1:0]      low_wr_data,
    input  logic                   ret_en,
    input  logic [PC_W-1:0]        ret_addr,
    input  logic                   latch_wr_en,
    input  logic [PC_W-DATA_W-1:0] latch_wr_data,
    output logic [PC_W-1:0]        fetch_addr,
    output logic [DATA_W-1:0]      low_rd_data,
    output logic [PC_W-1:0]        push_addr
);

    localparam int LAT_W = PC_W - DATA_W;

    typedef struct packed {
        logic [PC_W-1:0]  pc;
        logic [LAT_W-1:0] page;
    } pc_state_t;

    pc_state_t state_d, state_q;
    pc_src_e   src;
    logic [PC_W-1:0] seq_addr;
    logic [PC_W-1:0] branch_addr;
    logic [PC_W-1:0] low_addr;
    logic [LAT_W-1:0] page_val;

    pcu_select u_select (
        .inc_en    (inc_en),
        .jump_en   (jump_en),
        .call_en   (call_en),
        .low_wr_en (low_wr_en),
        .ret_en    (ret_en),
        .src       (src)
    );

    pcu_incr #(.W(PC_W)) u_incr (
        .cur (state_q.pc),
        .nxt (seq_addr)
    );

    pcu_target #(.PC_W(PC_W), .DATA_W(DATA_W), .OPC_W(OPC_W)) u_target (
        .page        (state_q.page),
        .opc_target  (branch_target),
        .low_data    (low_wr_data),
        .branch_addr (branch_addr),
        .low_addr    (low_addr)
    );

    always_comb begin
        state_d = state_q;
        unique case (src)
            SRC_RET:    state_d.pc = ret_addr;
            SRC_BRANCH: state_d.pc = branch_addr;
            SRC_LOW:    state_d.pc = low_addr;
            SRC_INC:    state_d.pc = seq_addr;
            default:    state_d.pc = state_q.pc;
        endcase
        if (latch_wr_en) begin
            state_d.page = latch_wr_data;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign page_val    = state_q.page;
    assign fetch_addr  = state_q.pc;
    assign low_rd_data = state_q.pc[DATA_W-1:0];
    assign push_addr   = seq_addr;

endmodule

// File: rtl/paged_pc_chk.sv
module paged_pc_chk #(
    parameter int PC_W   = 13,
    parameter int DATA_W = 8,
    parameter int OPC_W  = 11
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   inc_en,
    input logic                   jump_en,
    input logic                   call_en,
    input logic [OPC_W-1:0]       branch_target,
    input logic                   low_wr_en,
    input logic                   ret_en,
    input logic [PC_W-1:0]        ret_addr,
    input logic                   latch_wr_en,
    input logic [PC_W-DATA_W-1:0] page_val,
    input logic [PC_W-1:0]        fetch_addr,
    input logic [PC_W-1:0]        push_addr
);

    localparam int LAT_W = PC_W - DATA_W;
    localparam int PAGE_W = PC_W - OPC_W;

    logic any_ctl;
    assign any_ctl = inc_en | jump_en | call_en | low_wr_en | ret_en;

    p_reset_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (fetch_addr == '0 && page_val == '0));

    p_inc_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (inc_en && !jump_en && !call_en && !low_wr_en && !ret_en)
        |=> fetch_addr == $past(fetch_addr) + {{(PC_W-1){1'b0}}, 1'b1});

    p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !any_ctl |=> $stable(fetch_addr));

    p_branch_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ((jump_en || call_en) && !ret_en)
        |=> fetch_addr == {$past(page_val[LAT_W-1 -: PAGE_W]), $past(branch_target)});

    p_ret_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ret_en |=> fetch_addr == $past(ret_addr));

    p_page_kept_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !latch_wr_en |=> $stable(page_val));

    p_push_r8: assert property (@(posedge clk) disable iff (!rst_n)
        push_addr == fetch_addr + {{(PC_W-1){1'b0}}, 1'b1});

endmodule

bind paged_pc paged_pc_chk #(.PC_W(PC_W), .DATA_W(DATA_W), .OPC_W(OPC_W)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .inc_en        (inc_en),
    .jump_en       (jump_en),
    .call_en       (call_en),
    .branch_target (branch_target),
    .low_wr_en     (low_wr_en),
    .ret_en        (ret_en),
    .ret_addr      (ret_addr),
    .latch_wr_en   (latch_wr_en),
    .page_val      (page_val),
    .fetch_addr    (fetch_addr),
    .push_addr     (push_addr)
);

// File: tb/test_paged_pc.sv
module test_paged_pc;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        inc_en = 1'b0, jump_en = 1'b0, call_en = 1'b0;
    logic [10:0] branch_target = '0;
    logic        low_wr_en = 1'b0;
    logic [7:0]  low_wr_data = '0;
    logic        ret_en = 1'b0;
    logic [12:0] ret_addr = '0;
    logic        latch_wr_en = 1'b0;
    logic [4:0]  latch_wr_data = '0;
    logic [12:0] fetch_addr;
    logic [7:0]  low_rd_data;
    logic [12:0] push_addr;

    int n_checks = 0;
    int n_fail = 0;

    typedef struct {
        logic [12:0] pc;
        string       tag;
    } exp_t;
    exp_t sb_q[$];

    // Reference model state
    logic [12:0] m_pc = '0;
    logic [4:0]  m_page = '0;

    always #10 clk = ~clk;   // 50 MHz

    paged_pc i_paged_pc (
        .clk           (clk),
        .rst_n         (rst_n),
        .inc_en        (inc_en),
        .jump_en       (jump_en),
        .call_en       (call_en),
        .branch_target (branch_target),
        .low_wr_en     (low_wr_en),
        .low_wr_data   (low_wr_data),
        .ret_en        (ret_en),
        .ret_addr      (ret_addr),
        .latch_wr_en   (latch_wr_en),
        .latch_wr_data (latch_wr_data),
        .fetch_addr    (fetch_addr),
        .low_rd_data   (low_rd_data),
        .push_addr     (push_addr)
    );

    task automatic check13(input string tag, input logic [12:0] act, input logic [12:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%04h expected 0x%04h", tag, act, exp);
        end
    endtask

    // Driver: applies one cycle of stimulus at the falling edge and queues the result
    task automatic drive(input logic inc, input logic jmp, input logic cal,
                         input logic [10:0] tgt, input logic lw, input logic [7:0] ld,
                         input logic rt, input logic [12:0] ra,
                         input logic pw, input logic [4:0] pd, input string tag);
        exp_t it;
        @(negedge clk);
        inc_en = inc; jump_en = jmp; call_en = cal; branch_target = tgt;
        low_wr_en = lw; low_wr_data = ld; ret_en = rt; ret_addr = ra;
        latch_wr_en = pw; latch_wr_data = pd;
        #1;
        check13("R8 push_addr", push_addr, m_pc + 13'd1);
        if (rt)              m_pc = ra;
        else if (jmp || cal) m_pc = {m_page[4:3], tgt};
        else if (lw)         m_pc = {m_page, ld};
        else if (inc)        m_pc = m_pc + 13'd1;
        if (pw) m_page = pd;
        it.pc = m_pc;
        it.tag = tag;
        sb_q.push_back(it);
    endtask

    // Monitor: compares one queued result just after every rising edge
    initial begin
        forever begin
            @(posedge clk);
            #2;
            if (sb_q.size() > 0) begin
                exp_t it;
                it = sb_q.pop_front();
                check13(it.tag, fetch_addr, it.pc);
                check13("R9 low_rd_data", {5'd0, low_rd_data}, {5'd0, it.pc[7:0]});
            end
        end
    end

    initial begin
        repeat (5000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #2;
        check13("R1 reset fetch_addr", fetch_addr, 13'h0000);
        check13("R9 reset low_rd_data", {5'd0, low_rd_data}, 13'h0000);
        @(negedge clk);
        rst_n = 1'b1;

        // R2 sequential stepping
        drive(1, 0, 0, 11'h0, 0, 8'h00, 0, 13'h0, 0, 5'h0, "R2 increment");
        drive(1, 0, 0, 11'h0, 0, 8'h00, 0, 13'h0, 0, 5'h0, "R2 increment");
        drive(1, 0, 0, 11'h0, 0, 8'h00, 0, 13'h0, 0, 5'h0, "R2 increment");
        // R3 hold
        drive(0, 0, 0, 11'h0, 0, 8'h00, 0, 13'h0, 0, 5'h0, "R3 hold");
        drive(0, 0, 0, 11'h0, 0, 8'h00, 0, 13'h0, 0, 5'h0, "R3 hold");
        // R1/R5 low write with page still at reset value 0
        drive(0, 0, 0, 11'h0, 1, 8'h55, 0, 13'h0, 0, 5'h0, "R1 R5 low write, page 0");
        // R11 page write with same-cycle low write uses old page
        drive(0, 0, 0, 11'h0, 1, 8'hAA, 0, 13'h0, 1, 5'h1F, "R11 low write uses old page");
        // R5 low write with new page
        drive(0, 0, 0, 11'h0, 1, 8'h12, 0, 13'h0, 0, 5'h0, "R5 low write page 0x1F");
        // R4 jump to top of space
        drive(0, 1, 0, 11'h7FF, 0, 8'h00, 0, 13'h0, 0, 5'h0, "R4 jump");
        // R2 wrap
        drive(1, 0, 0, 11'h0, 0, 8'h00, 0, 13'h0, 0, 5'h0, "R2 wrap to zero");
        // Page write then call: page bits 4:3 = 01
        drive(0, 0, 0, 11'h0, 0, 8'h00, 0, 13'h0, 1, 5'h0A, "R3 hold during page write");
        drive(0, 0, 1, 11'h123, 0, 8'h00, 0, 13'h0, 0, 5'h0, "R4 call");
        // R10 priority
        drive(1, 1, 0, 11'h050, 1, 8'h77, 1, 13'h1ABC, 0, 5'h0, "R10 R6 return wins");
        drive(1, 1, 0, 11'h050, 1, 8'h77, 0, 13'h0, 0, 5'h0, "R10 jump beats low write");
        drive(1, 0, 0, 11'h0, 1, 8'h77, 0, 13'h0, 0, 5'h0, "R10 low write beats increment");
        // R6 return ignores the page register
        drive(0, 0, 0, 11'h0, 0, 8'h00, 1, 13'h0005, 0, 5'h0, "R6 return");
        // R7 page unchanged by the call, jump and returns above
        drive(0, 0, 0, 11'h0, 1, 8'h00, 0, 13'h0, 0, 5'h0, "R7 page kept after call/return");
        drive(1, 0, 0, 11'h0, 0, 8'h00, 0, 13'h0, 0, 5'h0, "R2 increment");
        drive(0, 0, 0, 11'h0, 0, 8'h00, 0, 13'h0, 0, 5'h0, "R3 hold");

        repeat (3) @(posedge clk);
        #3;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule